// File: doc/BRIEF.md
# Dual-Reload PWM Pulse-Train Timer

This block makes a pulse waveform whose high and low phases are set by two separate reload registers. A down-counting phase counter steps once per enable tick from an outside prescaler. Each time it underflows it reloads, taking the high-phase value and the low-phase value in turn. The high-phase register is always used for the first reload after a start. A second down counter has two uses. In pulse-train mode it counts finished pulses and stops the train after a programmed number. In plain mode it is a free-running periodic timer driven by its own tick.

A write port loads the two phase values and the count value. A start comes from one of three sources: a software strobe, a rising edge on an external trigger pin, or a falling edge on that pin. The pin passes through two synchronising flip-flops before edge detection. Three sticky event flags mark a high-phase reload, a low-phase reload and a second-counter underflow. Software clears them by writing ones.

Top module: `dual_reload_pwm`

## Requirements
- R1: The phase counter moves only on cycles where `tick1` is high. A reload value N gives a phase lasting N+1 ticks.
- R2: After a start, the first underflow reloads from the high-phase register (write address 0) and sets `pwm_out` high. Later underflows take the low-phase register (address 1, `pwm_out` low) and the high-phase register in turn.
- R3: The high and low durations are independent. A high phase shorter than the low phase, and one longer, both come out exactly as programmed.
- R4: Bit 0 of `irq_flags` is set on each high-phase reload, bit 1 on each low-phase reload, and bit 2 on each second-counter underflow. A flag stays set until a 1 is written to the same bit of `irq_clr`. If a set and a clear fall in the same cycle, the set wins.
- R5: A write to address 0 or 1 while running does not change the phase in progress. The new value is used at the next reload from that register.
- R6: With `train_mode`=1 and count register (address 2) = P, exactly P pulses are produced; P=0 counts as 1. Flag bit 2 is set when the last high phase ends. The timer stops when the following low phase ends, and `running` then falls.
- R7: With `train_mode`=0, the second counter decrements on each `tick2` while running. On underflow it reloads the count register and sets flag bit 2, so the period is count+1 ticks.
- R8: `trig_sel` selects the start source: 0 is a `sw_start` pulse, 1 is a rising edge of `ext_trig`, 2 is a falling edge of `ext_trig`. An edge of the unselected polarity does not start the timer.
- R9: A start of any kind that arrives while `running` is high has no effect on the waveform.
- R10: While idle, `pwm_out` is 0 and `running` is 0. `sw_stop` halts a running timer and drives `pwm_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick1 | input | 1 | Phase counter enable tick |
| tick2 | input | 1 | Second counter tick in plain mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 high phase, 1 low phase, 2 count |
| wr_data | input | W | Write data |
| train_mode | input | 1 | 1 pulse-train, 0 plain timer |
| trig_sel | input | 2 | Start source select |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software stop strobe |
| ext_trig | input | 1 | Asynchronous external trigger |
| irq_clr | input | 3 | Write-one-to-clear for flags |
| pwm_out | output | 1 | Waveform output |
| running | output | 1 | Timer active status |
| irq_flags | output | 3 | Sticky events: high reload, low reload, counter 2 underflow |

## Verification
A scoreboard measures each high and low run of `pwm_out` in clock cycles and compares it with (N+1) times the tick divider. This is done with the high phase shorter than the low phase, then longer, and with the prescaler ratio set to 1 and to 2. These cases separate a swapped or fixed reload source and an off-by-one phase length from a counter that ignores the tick. Further patterns cover a high-phase rewrite in the middle of a phase, which shows whether the shadow value is taken only at reload, and a repeated software start during a run. Pulse trains of three and of zero pulses check the exact count and the stop point. Edges of both polarities are applied under each trigger select, and plain mode is checked by timing the intervals between flag-bit-2 events.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef enum logic [1:0] {
        TRIG_SOFT = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2
    } trig_src_e;

    localparam logic [1:0] ADDR_HIGH  = 2'd0;
    localparam logic [1:0] ADDR_LOW   = 2'd1;
    localparam logic [1:0] ADDR_COUNT = 2'd2;

    localparam int FLAG_HIGH = 0;
    localparam int FLAG_LOW  = 1;
    localparam int FLAG_CNT2 = 2;
    localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/pwm_trig_sync.sv
module pwm_trig_sync
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_trig,
    input  logic [1:0] sel,
    input  logic       sw_start,
    output logic       start_req
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = ext_trig;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
        case (trig_src_e'(sel))
            TRIG_SOFT: start_req = sw_start;
            TRIG_RISE: start_req = sync_q.s2 & ~sync_q.prev;
            TRIG_FALL: start_req = ~sync_q.s2 & sync_q.prev;
            default:   start_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    input  logic         tick,
    input  logic         finish,
    input  logic [W-1:0] rld_high,
    input  logic [W-1:0] rld_low,
    output logic         level,
    output logic         evt_high,
    output logic         evt_low,
    output logic         train_end
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         next_high;
        logic         out;
    } phase_t;

    phase_t ph_q, ph_d;

    always_comb begin
        ph_d      = ph_q;
        evt_high  = 1'b0;
        evt_low   = 1'b0;
        train_end = 1'b0;
        if (start) begin
            ph_d.cnt       = '0;
            ph_d.next_high = 1'b1;
            ph_d.out       = 1'b0;
        end else if (!run) begin
            ph_d.out = 1'b0;
        end else if (tick) begin
            if (ph_q.cnt == '0) begin
                if (ph_q.next_high) begin
                    if (finish) begin
                        train_end = 1'b1;
                        ph_d.out  = 1'b0;
                    end else begin
                        ph_d.cnt       = rld_high;
                        ph_d.out       = 1'b1;
                        ph_d.next_high = 1'b0;
                        evt_high       = 1'b1;
                    end
                end else begin
                    ph_d.cnt       = rld_low;
                    ph_d.out       = 1'b0;
                    ph_d.next_high = 1'b1;
                    evt_low        = 1'b1;
                end
            end else begin
                ph_d.cnt = ph_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign level = ph_q.out;

    // R1: without a tick the count holds
    assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !start) |=> $stable(ph_q.cnt));
endmodule

// File: rtl/pwm_train_ctr.sv
module pwm_train_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    input  logic         train,
    input  logic         tick,
    input  logic         pulse,
    input  logic [W-1:0] rld,
    output logic         underflow,
    output logic         last
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         last;
    } train_t;

    train_t tr_q, tr_d;

    always_comb begin
        tr_d      = tr_q;
        underflow = 1'b0;
        if (start) begin
            tr_d.cnt  = (train && rld == '0) ? W'(1) : rld;
            tr_d.last = 1'b0;
        end else if (run) begin
            if (train) begin
                if (pulse) begin
                    if (tr_q.cnt <= W'(1)) begin
                        underflow = 1'b1;
                        tr_d.last = 1'b1;
                        tr_d.cnt  = '0;
                    end else begin
                        tr_d.cnt = tr_q.cnt - 1'b1;
                    end
                end
            end else if (tick) begin
                if (tr_q.cnt == '0) begin
                    tr_d.cnt  = rld;
                    underflow = 1'b1;
                end else begin
                    tr_d.cnt = tr_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign last = tr_q.last;
endmodule

// File: rtl/dual_reload_pwm.sv
module dual_reload_pwm
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick1,
    input  logic                 tick2,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic                 train_mode,
    input  logic [1:0]           trig_sel,
    input  logic                 sw_start,
    input  logic                 sw_stop,
    input  logic                 ext_trig,
    input  logic [NUM_FLAGS-1:0] irq_clr,
    output logic                 pwm_out,
    output logic                 running,
    output logic [NUM_FLAGS-1:0] irq_flags
);
    typedef struct packed {
        logic [W-1:0]         rld_high;
        logic [W-1:0]         rld_low;
        logic [W-1:0]         rld_cnt;
        logic [NUM_FLAGS-1:0] flags;
        logic                 run;
    } top_t;

    top_t st_q, st_d;

    logic start_req, start;
    logic level, evt_high, evt_low, train_end;
    logic cnt2_uf, cnt2_last;
    logic [NUM_FLAGS-1:0] evt_vec;

    assign start = start_req & ~st_q.run;

    pwm_trig_sync u_trig (
        .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .sel(trig_sel),
        .sw_start(sw_start), .start_req(start_req)
    );

    pwm_phase_ctr #(.W(W)) u_phase (
        .clk(clk), .rst_n(rst_n), .start(start), .run(st_q.run), .tick(tick1),
        .finish(cnt2_last & train_mode), .rld_high(st_q.rld_high),
        .rld_low(st_q.rld_low), .level(level), .evt_high(evt_high),
        .evt_low(evt_low), .train_end(train_end)
    );

    pwm_train_ctr #(.W(W)) u_train (
        .clk(clk), .rst_n(rst_n), .start(start), .run(st_q.run),
        .train(train_mode), .tick(tick2), .pulse(evt_low), .rld(st_q.rld_cnt),
        .underflow(cnt2_uf), .last(cnt2_last)
    );

    always_comb begin
        evt_vec            = '0;
        evt_vec[FLAG_HIGH] = evt_high;
        evt_vec[FLAG_LOW]  = evt_low;
        evt_vec[FLAG_CNT2] = cnt2_uf;

        st_d       = st_q;
        st_d.flags = (st_q.flags & ~irq_clr) | evt_vec;
        if (wr_en) begin
            case (wr_addr)
                ADDR_HIGH:  st_d.rld_high = wr_data;
                ADDR_LOW:   st_d.rld_low  = wr_data;
                ADDR_COUNT: st_d.rld_cnt  = wr_data;
                default: ;
            endcase
        end
        if (start)                      st_d.run = 1'b1;
        else if (sw_stop || train_end)  st_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_out   = level & st_q.run;
    assign running   = st_q.run;
    assign irq_flags = st_q.flags;

    // alternation tracker for the reload-order assertions
    logic high_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        high_seen_q <= 1'b0;
        else if (start)    high_seen_q <= 1'b0;
        else if (evt_high) high_seen_q <= 1'b1;
        else if (evt_low)  high_seen_q <= 1'b0;
    end

    assert_low_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_low |-> high_seen_q);

    assert_high_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_high |-> !high_seen_q);

    assert_rise_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> irq_flags[FLAG_HIGH]);

    assert_stop_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.run) && !$past(sw_stop)) |-> $past(cnt2_last));
endmodule

// File: tb/test_dual_reload_pwm.sv
module test_dual_reload_pwm;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick1 = 1'b0, tick2 = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic train_mode = 1'b0;
    logic [1:0] trig_sel = '0;
    logic sw_start = 1'b0, sw_stop = 1'b0, ext_trig = 1'b0;
    logic [2:0] irq_clr = '0;
    logic pwm_out, running;
    logic [2:0] irq_flags;

    always #4 clk = ~clk;

    dual_reload_pwm #(.W(W)) i_dual_reload_pwm (
        .clk(clk), .rst_n(rst_n), .tick1(tick1), .tick2(tick2),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .train_mode(train_mode), .trig_sel(trig_sel), .sw_start(sw_start),
        .sw_stop(sw_stop), .ext_trig(ext_trig), .irq_clr(irq_clr),
        .pwm_out(pwm_out), .running(running), .irq_flags(irq_flags)
    );

    int errors = 0, checks = 0;
    int cyc = 0;
    int div = 1;
    int divcnt = 0;
    int expq[$];
    bit seen_high = 0;
    logic lvl = 1'b0;
    int t_chg = 0;
    int rises = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // tick generator: tick1 high once every div cycles
    always @(negedge clk) begin
        cyc++;
        divcnt = (divcnt + 1) % div;
        tick1 <= (divcnt == div - 1);
    end

    // monitor: measures output runs and pops expected items
    always @(negedge clk) begin
        if (pwm_out !== lvl) begin
            int len;
            len = cyc - t_chg;
            if ((lvl == 1'b1 || seen_high) && expq.size() > 0) begin
                int e;
                e = expq.pop_front();
                check((e % 2) == int'(lvl), "R2 phase level", int'(lvl), e % 2);
                check(len == e / 2, "R1/R3 phase length", len, e / 2);
            end
            if (lvl == 1'b1) seen_high = 1;
            if (pwm_out == 1'b1) rises++;
            lvl = pwm_out;
            t_chg = cyc;
        end
    end

    task automatic arm();
        expq.delete();
        seen_high = 0;
        rises = 0;
    endtask

    task automatic push_phase(input bit l, input int n);
        expq.push_back((n + 1) * div * 2 + int'(l));
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); sw_stop = 1'b1;
        @(negedge clk); sw_stop = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_empty(input string req);
        for (int i = 0; i < 3000 && expq.size() > 0; i++) @(negedge clk);
        check(expq.size() == 0, req, expq.size(), 0);
    endtask

    task automatic clear_flags();
        @(negedge clk); irq_clr = 3'b111;
        @(negedge clk); irq_clr = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        int times[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(pwm_out == 1'b0, "R10 reset pwm", int'(pwm_out), 0);
        check(running == 1'b0, "R10 reset running", int'(running), 0);
        check(irq_flags == 3'b000, "R4 reset flags", int'(irq_flags), 0);

        // R1 R2 R3: high shorter than low, divider 2
        div = 2;
        wr(2'd0, 2); wr(2'd1, 5); wr(2'd2, 1000);
        arm();
        push_phase(1, 2); push_phase(0, 5); push_phase(1, 2); push_phase(0, 5); push_phase(1, 2);
        pulse_start();
        check(running == 1'b1, "R10 running after start", int'(running), 1);
        wait_empty("R3 short-high pattern complete");
        check(irq_flags == 3'b011, "R4 reload flags", int'(irq_flags), 3);
        pulse_stop();
        check(pwm_out == 1'b0 && running == 1'b0, "R10 stop drives low", int'(pwm_out) + int'(running), 0);
        // R4 sticky and W1C
        check(irq_flags == 3'b011, "R4 flags sticky", int'(irq_flags), 3);
        @(negedge clk); irq_clr = 3'b001;
        @(negedge clk); irq_clr = 3'b000;
        check(irq_flags == 3'b010, "R4 partial clear", int'(irq_flags), 2);
        clear_flags();
        check(irq_flags == 3'b000, "R4 full clear", int'(irq_flags), 0);

        // R3: high longer than low, divider 1
        div = 1;
        wr(2'd0, 6); wr(2'd1, 2);
        arm();
        push_phase(1, 6); push_phase(0, 2); push_phase(1, 6);
        pulse_start();
        wait_empty("R3 long-high pattern complete");
        pulse_stop();

        // R5: rewrite high value during first high phase
        wr(2'd0, 3); wr(2'd1, 2);
        arm();
        push_phase(1, 3); push_phase(0, 2); push_phase(1, 1);
        pulse_start();
        @(negedge clk);
        wr(2'd0, 1);
        wait_empty("R5 shadow reload");
        pulse_stop();

        // R9: software start during run is ignored
        wr(2'd0, 2); wr(2'd1, 2);
        arm();
        push_phase(1, 2); push_phase(0, 2); push_phase(1, 2); push_phase(0, 2); push_phase(1, 2);
        pulse_start();
        @(negedge clk);
        pulse_start();
        repeat (4) @(negedge clk);
        pulse_start();
        wait_empty("R9 restart ignored");
        pulse_stop();
        clear_flags();

        // R6: pulse train of 3
        train_mode = 1'b1;
        wr(2'd0, 1); wr(2'd1, 1); wr(2'd2, 3);
        arm();
        push_phase(1, 1); push_phase(0, 1); push_phase(1, 1); push_phase(0, 1); push_phase(1, 1);
        pulse_start();
        wait_empty("R6 train phases");
        repeat (10) @(negedge clk);
        check(running == 1'b0, "R6 train stops", int'(running), 0);
        check(rises == 3, "R6 pulse count", rises, 3);
        check(irq_flags[2] == 1'b1, "R6 end flag", int'(irq_flags[2]), 1);
        repeat (20) @(negedge clk);
        check(rises == 3 && pwm_out == 1'b0, "R6 no pulses after end", rises, 3);
        clear_flags();

        // R6: count 0 behaves as 1
        wr(2'd2, 0);
        arm();
        pulse_start();
        repeat (20) @(negedge clk);
        check(rises == 1, "R6 zero count gives one pulse", rises, 1);
        check(running == 1'b0, "R6 zero count stops", int'(running), 0);
        train_mode = 1'b0;
        clear_flags();

        // R8: external trigger rising select
        trig_sel = 2'd1;
        @(negedge clk); ext_trig = 1'b1;
        repeat (6) @(negedge clk);
        check(running == 1'b1, "R8 rising edge starts", int'(running), 1);
        pulse_stop();
        @(negedge clk); ext_trig = 1'b0;
        repeat (6) @(negedge clk);
        check(running == 1'b0, "R8 falling edge ignored under rise select", int'(running), 0);
        // falling select
        trig_sel = 2'd2;
        @(negedge clk); ext_trig = 1'b1;
        repeat (6) @(negedge clk);
        check(running == 1'b0, "R8 rising edge ignored under fall select", int'(running), 0);
        @(negedge clk); ext_trig = 1'b0;
        repeat (6) @(negedge clk);
        check(running == 1'b1, "R8 falling edge starts", int'(running), 1);
        pulse_stop();
        trig_sel = 2'd0;

        // R7: plain mode periodic counter 2
        wr(2'd0, 1000); wr(2'd2, 4);
        clear_flags();
        tick2 = 1'b1;
        pulse_start();
        for (int i = 0; i < 40 && times.size() < 4; i++) begin
            @(negedge clk);
            irq_clr = 3'b000;
            if (irq_flags[2]) begin
                times.push_back(cyc);
                irq_clr = 3'b100;
            end
        end
        irq_clr = 3'b000;
        check(times.size() == 4, "R7 underflow events seen", times.size(), 4);
        if (times.size() == 4) begin
            for (int k = 1; k < 4; k++)
                check(times[k] - times[k-1] == 5, "R7 period count+1", times[k] - times[k-1], 5);
        end
        tick2 = 1'b0;
        pulse_stop();

        summary();
    end
endmodule